// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the slave side of a two-wire serial bus (I2C-style), built to run in the system clock domain. It samples the bus clock and data lines and finds START and STOP conditions on them. It then shifts in an address byte, MSB first, whose last bit gives the direction. When the address matches, the block acknowledges by pulling the data line low through an open-drain enable. A small bank of byte-wide registers sits behind a pointer.

The seven-bit bus address is a fixed high part followed by three strap inputs. The strap inputs are read once after reset and again at every START. Between those moments the held copy is used. A write transaction always begins with a pointer byte. Any further bytes in that transaction go into the register that the pointer selects. A read returns the selected register. The master acknowledges to ask for another byte, or answers with a not-acknowledge to end the transfer.

Top module: `ptr_i2c_slave`

## Requirements
- R1: While reset is low and after it is released, `sda_pull_o` is 0 and the pointer is 0. Register i holds 0xA0 + i after reset.
- R2: The bus address is binary 1001 followed by strap bits [2], [1], [0]. After an address byte with that address, the block holds `sda_pull_o` high for the ninth clock pulse. An acknowledge is seen as SDA low while SCL is high.
- R3: After an address byte that does not match, the block does not acknowledge that byte. It leaves SDA released until the next START, and the register contents and the pointer are unchanged.
- R4: The strap inputs are captured after reset and on each START. A change on the strap inputs after a START has no effect on the address compared in that transaction. The next START uses the new value.
- R5: The first byte after a matching write-address byte is acknowledged and becomes the pointer. A write that carries only this byte changes only the pointer.
- R6: Each further byte in the same write transaction is acknowledged and written to register (pointer mod 4) with 4 registers. The pointer does not move, so later bytes overwrite the same register.
- R7: A read transaction sends the register selected by the latest pointer, MSB first, with bit values driven while SCL is low. Reads leave the pointer unchanged.
- R8: During a read, an acknowledge from the master (SDA low on the ninth pulse) makes the block send the selected register again. A not-acknowledge makes it release SDA and drive nothing until the next START.
- R9: A repeated START at any bit position abandons the current byte and restarts address reception. A data byte cut short this way is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| strap_i | input | 3 | Address strap levels, forming the low address bits |
| sda_pull_o | output | 1 | Open-drain enable for SDA, 1 pulls the line low |

## Verification
The bench builds the block with its default parameters: four registers, a two-stage synchronizer and the 1001 high address part. With four registers, pointer values of 4 and above fold back onto the low registers, so the index wrap is reachable with short transactions. The strap value 010 gives the address 0x4A. Switching the straps to 111 in the middle of a transaction shows both the held address and the fresh capture at the next START.

// File: rtl/ptr_i2c_pkg.sv
package ptr_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting in a byte
    ST_ACK,    // driving acknowledge on ninth pulse
    ST_TX,     // shifting out a byte
    ST_MACK,   // waiting for master acknowledge sample
    ST_MEND    // waiting for end of master acknowledge pulse
  } st_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } by_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign sda_o     = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/strap_addr_latch.sv
module strap_addr_latch #(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic              init_pend;
  logic [STRAP_W-1:0] strap_q;
  logic              load;

  assign load = init_pend | capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_pend <= 1'b1;
      strap_q   <= '0;
    end else begin
      init_pend <= 1'b0;
      if (load) strap_q <= strap_i;
    end
  end

  assign addr_o = {ADDR_HI, strap_q};
endmodule

// File: rtl/ptr_reg_bank.sv
module ptr_reg_bank #(
  parameter int NREG     = 4,
  parameter int DW       = 8,
  parameter int RST_BASE = 'hA0,
  localparam int IDXW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] q_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RV = DW'(RST_BASE + g);
    logic [DW-1:0] q;
    logic          we;
    assign we = wr_en && (idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV;
      else if (we) q <= wdata;
    end
    assign q_arr[g] = q;
  end

  assign rdata = q_arr[idx];
endmodule

// File: rtl/ptr_i2c_slave.sv
module ptr_i2c_slave
  import ptr_i2c_pkg::*;
#(
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int STRAP_W     = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b1001,
  parameter int RST_BASE    = 'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o
);
  localparam int BW   = ADDR_W + 1;
  localparam int IDXW = $clog2(NREG);
  localparam int CW   = $clog2(BW + 1);
  localparam logic [CW-1:0] LAST = CW'(BW);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] addr_lat;
  logic [BW-1:0]     rdata;
  logic              wr_en;

  st_t             state, n_state;
  by_t             kind, n_kind;
  logic [CW-1:0]   cnt, n_cnt;
  logic [BW-1:0]   sh, n_sh;
  logic [IDXW-1:0] ptr_q, n_ptr;
  logic            rw, n_rw, mack, n_mack, pull, n_pull;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  strap_addr_latch #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_addr (
    .clk(clk), .rst_n(rst_n), .capture(start_det), .strap_i(strap_i), .addr_o(addr_lat)
  );

  ptr_reg_bank #(.NREG(NREG), .DW(BW), .RST_BASE(RST_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(ptr_q), .wdata(sh), .rdata(rdata)
  );

  always_comb begin
    n_state = state;
    n_kind  = kind;
    n_cnt   = cnt;
    n_sh    = sh;
    n_ptr   = ptr_q;
    n_rw    = rw;
    n_mack  = mack;
    n_pull  = pull;
    wr_en   = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_RX: begin
        if (scl_rise) begin
          n_sh  = {sh[BW-2:0], sda_s};
          n_cnt = cnt + 1'b1;
        end else if (scl_fall && cnt == LAST) begin
          unique case (kind)
            BY_ADDR: begin
              if (sh[BW-1:1] == addr_lat) begin
                n_rw    = sh[0];
                n_state = ST_ACK;
                n_pull  = 1'b1;
              end else begin
                n_state = ST_IDLE;
              end
            end
            BY_PTR: begin
              n_ptr   = sh[IDXW-1:0];
              n_state = ST_ACK;
              n_pull  = 1'b1;
            end
            default: begin
              wr_en   = 1'b1;
              n_state = ST_ACK;
              n_pull  = 1'b1;
            end
          endcase
        end
      end
      ST_ACK: begin
        if (scl_fall) begin
          n_cnt = '0;
          if (kind == BY_ADDR && rw) begin
            n_state = ST_TX;
            n_sh    = rdata;
            n_pull  = ~rdata[BW-1];
          end else begin
            n_state = ST_RX;
            n_pull  = 1'b0;
            n_kind  = (kind == BY_ADDR) ? BY_PTR : BY_DATA;
          end
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          if (cnt == LAST - 1'b1) begin
            n_state = ST_MACK;
            n_pull  = 1'b0;
          end else begin
            n_sh   = {sh[BW-2:0], 1'b0};
            n_pull = ~sh[BW-2];
            n_cnt  = cnt + 1'b1;
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) begin
          n_mack  = ~sda_s;
          n_state = ST_MEND;
        end
      end
      ST_MEND: begin
        if (scl_fall) begin
          if (mack) begin
            n_state = ST_TX;
            n_cnt   = '0;
            n_sh    = rdata;
            n_pull  = ~rdata[BW-1];
          end else begin
            n_state = ST_IDLE;
          end
        end
      end
      default: n_state = ST_IDLE;
    endcase
    if (stop_det) begin
      n_state = ST_IDLE;
      n_pull  = 1'b0;
    end
    if (start_det) begin
      n_state = ST_RX;
      n_kind  = BY_ADDR;
      n_cnt   = '0;
      n_pull  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= BY_ADDR;
      cnt   <= '0;
      sh    <= '0;
      ptr_q <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      pull  <= 1'b0;
    end else begin
      state <= n_state;
      kind  <= n_kind;
      cnt   <= n_cnt;
      sh    <= n_sh;
      ptr_q <= n_ptr;
      rw    <= n_rw;
      mack  <= n_mack;
      pull  <= n_pull;
    end
  end

  assign sda_pull_o = pull;
endmodule

// File: rtl/ptr_i2c_slave_chk.sv
module ptr_i2c_slave_chk
  import ptr_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDXW   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull_o,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input st_t               st,
  input logic [IDXW-1:0]   ptr,
  input logic [ADDR_W-1:0] addr
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o);                                   // R3
  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK) |-> sda_pull_o);                                     // R2
  AST_PULL_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall | start_det | stop_det));   // R7
  AST_MASTER_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK || st == ST_MEND) |-> !sda_pull_o);                  // R8
  AST_PTR_HELD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX) |=> $stable(ptr));                                    // R7
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && !start_det) |=> $stable(addr));                     // R4
endmodule

bind ptr_i2c_slave ptr_i2c_slave_chk #(.ADDR_W(ADDR_W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .st(state), .ptr(ptr_q), .addr(addr_lat)
);

// File: tb/ptr_i2c_slave_test.sv
module ptr_i2c_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic [2:0] strap = 3'b010;
  logic sda_pull_o;
  logic sda_line;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  assign sda_line = ~(m_pull | sda_pull_o);

  ptr_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_pull = 1'b0; idle(Q);
    scl = 1'b1;    idle(Q);
    m_pull = 1'b1; idle(Q);
    scl = 1'b0;    idle(Q);
  endtask

  task automatic bus_stop;
    m_pull = 1'b1; idle(Q);
    scl = 1'b1;    idle(Q);
    m_pull = 1'b0; idle(2*Q);
  endtask

  task automatic wr_bit(input logic b);
    m_pull = ~b; idle(Q);
    scl = 1'b1;  idle(2*Q);
    scl = 1'b0;  idle(Q);
  endtask

  task automatic rd_bit(output logic b);
    m_pull = 1'b0; idle(Q);
    scl = 1'b1;    idle(Q);
    b = sda_line;  idle(Q);
    scl = 1'b0;    idle(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rd_bit(d[i]);
    wr_bit(~ack);
  endtask

  task automatic read_one(string tag, logic [7:0] exp);
    logic a; logic [7:0] d;
    bus_start;
    wr_byte(8'h95, a); chk({tag, " addr ack"}, {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);  chk(tag, d, exp);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R1 pull idle", {7'd0, sda_pull_o}, 8'd0);
    read_one("R1 reg0 reset via ptr 0", 8'hA0);
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start;
    wr_byte(8'h96, a); chk("R3 no ack on 0x4B", {7'd0, a}, 8'd0);
    wr_byte(8'h02, a); chk("R3 no ack on later byte", {7'd0, a}, 8'd0);
    wr_byte(8'h55, a); chk("R3 still released", {7'd0, a}, 8'd0);
    bus_stop;
    read_one("R3 state unchanged", 8'hA0);
  endtask

  task automatic t_write;
    logic a;
    bus_start;
    wr_byte(8'h94, a); chk("R2 ack on 0x4A", {7'd0, a}, 8'd1);
    wr_byte(8'h02, a); chk("R5 ptr ack", {7'd0, a}, 8'd1);
    wr_byte(8'h5C, a); chk("R6 data ack", {7'd0, a}, 8'd1);
    bus_stop;
    read_one("R7 read reg2", 8'h5C);
    read_one("R7 pointer kept", 8'h5C);
  endtask

  task automatic t_multi;
    logic a; logic [7:0] d;
    bus_start;
    wr_byte(8'h94, a); wr_byte(8'h01, a);
    wr_byte(8'h11, a); chk("R6 first data ack", {7'd0, a}, 8'd1);
    wr_byte(8'h22, a); chk("R6 second data ack", {7'd0, a}, 8'd1);
    bus_stop;
    read_one("R6 same reg overwritten", 8'h22);
    bus_start;
    wr_byte(8'h94, a); wr_byte(8'h02, a);
    bus_start;
    wr_byte(8'h95, a); chk("R5 read after ptr-only", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);  chk("R5 ptr-only write", d, 8'h5C);
    bus_stop;
  endtask

  task automatic t_wrap;
    logic a;
    bus_start;
    wr_byte(8'h94, a); wr_byte(8'h06, a); wr_byte(8'h77, a);
    bus_stop;
    bus_start;
    wr_byte(8'h94, a); wr_byte(8'h02, a);
    bus_stop;
    read_one("R6 ptr 6 hits reg2", 8'h77);
  endtask

  task automatic t_burst;
    logic a, b; logic [7:0] d;
    bus_start;
    wr_byte(8'h95, a);
    rd_byte(d, 1'b1); chk("R8 byte 1", d, 8'h77);
    rd_byte(d, 1'b1); chk("R8 byte 2 after ack", d, 8'h77);
    rd_byte(d, 1'b0); chk("R8 byte 3", d, 8'h77);
    rd_bit(b);        chk("R8 released after nack", {7'd0, b}, 8'd1);
    bus_stop;
  endtask

  task automatic t_strap;
    logic a; logic [7:0] d;
    bus_start;
    strap = 3'b111;
    wr_byte(8'h95, a); chk("R4 held strap ack", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);
    bus_stop;
    bus_start;
    wr_byte(8'h9F, a); chk("R4 new strap 0x4F ack", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);  chk("R4 read via 0x4F", d, 8'h77);
    bus_stop;
    bus_start;
    wr_byte(8'h95, a); chk("R4 old address refused", {7'd0, a}, 8'd0);
    bus_stop;
    strap = 3'b010;
  endtask

  task automatic t_rstart;
    logic a; logic [7:0] d;
    bus_start;
    wr_byte(8'h94, a); wr_byte(8'h03, a);
    wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    bus_start;
    wr_byte(8'h95, a); chk("R9 address after repeated start", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);  chk("R9 cut byte not written", d, 8'hA3);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(6);
    rst_n = 1'b1;
    idle(6);
    t_reset;
    t_mismatch;
    t_write;
    t_multi;
    t_wrap;
    t_burst;
    t_strap;
    t_rstart;
    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule